// File: doc/BRIEF.md
# Reloadable Transfer Counter

This unit holds the byte count for a DMA-capable storage bus controller. Software writes three byte-wide count registers, which fill a shadow copy of the count. The shadow copy does not move into the live counter when those registers are written. It moves only when a command byte arrives with its DMA flag set. If the command is the transfer-information command, the unit then counts down the live value as the data path accepts bytes. When the count reaches zero, it raises terminal-count status and bus-service status and emits a one-cycle done pulse.

The unit also drives the effective transfer length, which is the smaller of the live count and the magnitude of a signed byte residual supplied by the surrounding controller. The most significant count byte reads back a fixed identifier value until software first writes that register, so drivers can use it to probe which chip is present. A three-state machine sequences the work. IDLE goes to RUN on a DMA transfer command. RUN goes to DONE when the count becomes zero. DONE goes back to IDLE after one cycle. A new DMA transfer command restarts RUN from any state.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset the live count is zero, status flags and the done pulse are low, and reading byte 2 returns CHIP_ID (default 8'hA5).
- R2: Writing a count byte (select 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16) changes only the shadow count. The live count read back is unchanged.
- R3: A command whose bit 7 (DMA flag) is set copies the whole shadow count into the live count at that edge. A command with bit 7 clear leaves the live count unchanged.
- R4: Reading byte 2 returns CHIP_ID until byte 2 has been written once since reset. After that it returns bits 23:16 of the live count.
- R5: xfer_len always equals the minimum of the live count and the absolute value of the signed residual input.
- R6: A command whose low seven bits are 7'h10 (transfer-information) clears terminal-count status at its edge. If bit 7 is also set, the FSM enters RUN. If bit 7 is clear, no counting starts.
- R7: In RUN, each edge with xfer_valid high lowers the live count by xfer_bytes, saturating at zero.
- R8: At the edge where the live count becomes zero in RUN, terminal-count and bus-service status are set. done is high for exactly the following cycle, and all three count bytes read as zero.
- R9: A DMA transfer command loaded with a zero count reaches DONE on the next edge without any byte being accepted.
- R10: Bus-service status stays set until the next accepted command of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| reg_wr | input | 1 | Count byte write strobe |
| reg_sel | input | 2 | Byte lane for write |
| reg_wdata | input | 8 | Write data |
| rd_sel | input | 2 | Byte lane for readback |
| rd_data | output | 8 | Readback byte |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte, bit 7 = DMA flag |
| xfer_valid | input | 1 | Bytes accepted this cycle |
| xfer_bytes | input | 4 | Number of bytes accepted |
| residual | input | 25 | Signed remaining byte residual |
| xfer_len | output | 24 | Effective transfer length |
| tc_status | output | 1 | Terminal-count status |
| bus_service | output | 1 | Bus-service cause |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: a 24-bit count, a 4-bit step and CHIP_ID 8'hA5. With these values, a count of 16 stepped by 5 passes through a short partial step, which tests saturation. The full 24-bit width lets a residual larger than the count and a negative residual both be tested against xfer_len. The chip-ID value is distinct from any count byte the bench loads, so a readback that is armed when it should not be (or the reverse) is visible on byte 2.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } xc_state_t;

    localparam logic [6:0] OP_XFER_INFO = 7'h10;
    localparam int         DMA_BIT      = 7;
endpackage

// File: rtl/xfer_cnt_shadow.sv
module xfer_cnt_shadow #(
    parameter int CNT_W = 24,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] shadow,
    output logic             top_written
);
    localparam int NB = CNT_W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow[b*8 +: 8] <= '0;
            else if (wr && sel == SEL_W'(b))
                shadow[b*8 +: 8] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            top_written <= 1'b0;
        else if (wr && sel == SEL_W'(NB - 1))
            top_written <= 1'b1;
    end
endmodule

// File: rtl/xfer_cnt_live.sv
module xfer_cnt_live #(
    parameter int CNT_W  = 24,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              dec_en,
    input  logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  next_count
);
    logic [CNT_W-1:0] step_ext;

    always_comb begin
        step_ext = CNT_W'(step);
        if (load)
            next_count = load_val;
        else if (dec_en)
            next_count = (step_ext >= count) ? '0 : count - step_ext;
        else
            next_count = count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else
            count <= next_count;
    end
endmodule

// File: rtl/xfer_cnt_fsm.sv
module xfer_cnt_fsm
    import xfer_cnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_any,
    input  logic      cmd_xfer,
    input  logic      start_run,
    input  logic      next_zero,
    output xc_state_t state,
    output logic      done,
    output logic      tc_status,
    output logic      bus_service
);
    xc_state_t state_nx;
    logic      finish;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start_run) state_nx = S_RUN;
            S_RUN: begin
                if (start_run)      state_nx = S_RUN;
                else if (next_zero) state_nx = S_DONE;
            end
            S_DONE: state_nx = start_run ? S_RUN : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    assign finish = (state == S_RUN) && !start_run && next_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_status   <= 1'b0;
            bus_service <= 1'b0;
        end else begin
            if (cmd_xfer)    tc_status <= 1'b0;
            else if (finish) tc_status <= 1'b1;
            if (cmd_any)     bus_service <= 1'b0;
            else if (finish) bus_service <= 1'b1;
        end
    end

    assign done = (state == S_DONE);
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
    import xfer_cnt_pkg::*;
#(
    parameter int         CNT_W   = 24,
    parameter int         STEP_W  = 4,
    parameter int         RES_W   = 25,
    parameter logic [7:0] CHIP_ID = 8'hA5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_sel,
    input  logic [7:0]              reg_wdata,
    input  logic [1:0]              rd_sel,
    output logic [7:0]              rd_data,
    input  logic                    cmd_valid,
    input  logic [7:0]              cmd_byte,
    input  logic                    xfer_valid,
    input  logic [STEP_W-1:0]       xfer_bytes,
    input  logic signed [RES_W-1:0] residual,
    output logic [CNT_W-1:0]        xfer_len,
    output logic                    tc_status,
    output logic                    bus_service,
    output logic                    done
);
    localparam int NB = CNT_W / 8;
    localparam int MW = (RES_W > CNT_W) ? RES_W : CNT_W;

    logic [CNT_W-1:0] shadow, count, next_count;
    logic             top_written;
    logic             cmd_dma, cmd_xfer, start_run;
    xc_state_t        state;
    logic [MW-1:0]    res_mag, cnt_ext;

    assign cmd_dma   = cmd_valid && cmd_byte[DMA_BIT];
    assign cmd_xfer  = cmd_valid && (cmd_byte[6:0] == OP_XFER_INFO);
    assign start_run = cmd_xfer && cmd_byte[DMA_BIT];

    xfer_cnt_shadow #(.CNT_W(CNT_W), .SEL_W(2)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .shadow(shadow), .top_written(top_written)
    );

    xfer_cnt_live #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_live (
        .clk(clk), .rst_n(rst_n), .load(cmd_dma), .load_val(shadow),
        .dec_en(state == S_RUN && xfer_valid), .step(xfer_bytes),
        .count(count), .next_count(next_count)
    );

    xfer_cnt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_any(cmd_valid), .cmd_xfer(cmd_xfer),
        .start_run(start_run), .next_zero(next_count == '0),
        .state(state), .done(done), .tc_status(tc_status),
        .bus_service(bus_service)
    );

    always_comb begin
        rd_data = 8'h00;
        for (int b = 0; b < NB; b++)
            if (rd_sel == 2'(b)) rd_data = count[b*8 +: 8];
        if (rd_sel == 2'(NB - 1) && !top_written)
            rd_data = CHIP_ID;
    end

    always_comb begin
        res_mag  = residual[RES_W-1] ? MW'(-residual) : MW'(residual);
        cnt_ext  = MW'(count);
        xfer_len = (res_mag < cnt_ext) ? CNT_W'(res_mag) : count;
    end
endmodule

// File: rtl/xfer_count_checker.sv
module xfer_count_checker
    import xfer_cnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [7:0]       cmd_byte,
    input logic [CNT_W-1:0] shadow,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] xfer_len,
    input xc_state_t        state,
    input logic             done,
    input logic             tc_status
);
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[DMA_BIT]) |=> count == $past(shadow));

    assert_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !cmd_valid) |=> count <= $past(count));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(cmd_valid && cmd_byte[DMA_BIT])) |=> !done);

    assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tc_status && count == '0));

    assert_tc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[6:0] == OP_XFER_INFO) |=> !tc_status);

    assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_len <= count);
endmodule

bind xfer_count_unit xfer_count_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .shadow(shadow), .count(count), .xfer_len(xfer_len), .state(state),
    .done(done), .tc_status(tc_status)
);

// File: tb/xfer_count_unit_test.sv
`timescale 1ns/1ps
module xfer_count_unit_test;
    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, cmd_valid = 0, xfer_valid = 0;
    logic [1:0]  reg_sel = 0, rd_sel = 0;
    logic [7:0]  reg_wdata = 0, cmd_byte = 0, rd_data;
    logic [3:0]  xfer_bytes = 0;
    logic signed [24:0] residual = 0;
    logic [23:0] xfer_len;
    logic        tc_status, bus_service, done;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    xfer_count_unit uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        rd_sel = s; #1; v = rd_data;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1; reg_wr = 0;
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk); cmd_valid = 1; cmd_byte = c;
        @(posedge clk); #1; cmd_valid = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(0, v); chk("R1 low", v, 0);
        rd(2, v); chk("R1 chip id", v, 8'hA5);
        chk("R1 flags", {tc_status, bus_service, done}, 0);
    endtask

    task automatic t_shadow_load;
        logic [7:0] v;
        wr_reg(0, 8'h34); wr_reg(1, 8'h12);
        rd(0, v); chk("R2 live unchanged", v, 0);
        cmd(8'h00);
        rd(0, v); chk("R3 no-dma no load", v, 0);
        cmd(8'h80);
        rd(0, v); chk("R3 load low", v, 8'h34);
        rd(1, v); chk("R3 load mid", v, 8'h12);
        rd(2, v); chk("R4 id before write", v, 8'hA5);
        wr_reg(2, 8'h00);
        rd(2, v); chk("R4 live high after write", v, 8'h00);
        residual = 25'sd256; #1; chk("R5 residual smaller", xfer_len, 24'h100);
        residual = -25'sd8192; #1; chk("R5 negative residual", xfer_len, 24'h1234);
        residual = 0;
    endtask

    task automatic t_run;
        logic [7:0] v;
        wr_reg(0, 8'h10); wr_reg(1, 8'h00);
        cmd(8'h90);
        chk("R6 tc low at start", tc_status, 0);
        @(negedge clk); xfer_valid = 1; xfer_bytes = 5;
        for (int i = 0; i < 3; i++) @(posedge clk);
        #1; rd(0, v); chk("R7 count after 3 steps", v, 8'h01);
        chk("R7 no done yet", done, 0);
        @(posedge clk); #1; xfer_valid = 0;
        chk("R8 done", done, 1);
        chk("R8 tc", tc_status, 1);
        chk("R8 bus service", bus_service, 1);
        for (int b = 0; b < 3; b++) begin
            rd(2'(b), v); chk("R8 bytes zero", v, 0);
        end
        @(posedge clk); #1;
        chk("R8 done single", done, 0);
        chk("R10 bus service held", bus_service, 1);
    endtask

    task automatic t_nodma_xfer;
        logic [7:0] v;
        cmd(8'h10);
        chk("R6 tc cleared", tc_status, 0);
        chk("R10 bus service cleared", bus_service, 0);
        rd(0, v); chk("R6 no load no count", v, 0);
        @(posedge clk); #1; chk("R6 no done", done, 0);
    endtask

    task automatic t_zero;
        wr_reg(0, 8'h00);
        cmd(8'h90);
        chk("R9 not done at load", done, 0);
        @(posedge clk); #1;
        chk("R9 done without bytes", done, 1);
        chk("R9 tc", tc_status, 1);
    endtask

    task automatic t_rearm;
        logic [7:0] v;
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; #1;
        rd(2, v); chk("R1 id rearmed", v, 8'hA5);
        chk("R1 tc after reset", tc_status, 0);
    endtask

    initial begin
        #20; @(negedge clk); rst_n = 1; #1;
        t_reset;
        t_shadow_load;
        t_run;
        t_nodma_xfer;
        t_zero;
        t_rearm;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule